// File: doc/BRIEF.md
# Memory Window Region Decoder

This block classifies every CPU access that falls inside an 8 MB main-memory window. A 3-bit map-type field, held in a 32-bit control word, splits the window into a RAM part, an optional floating (high-impedance) part and an invalid part. Each access gets exactly one outcome: a RAM hit with a physical offset, a floating access that reads as all ones, or a bus error.

The installed RAM may be smaller than the region the map type declares. In that case the RAM is mirrored rather than rejected. With 2 MB fitted and a full-window map, the same 2 MB appears four times, so a write 2, 4 or 6 MB above a location lands on that location.

Decode is combinational. All results appear on registered outputs one clock after the access strobe. The control word is written with a single-cycle enable. The map type resets to the full-window encoding 101.

Top module: `mem_window_decoder`

## Requirements
- R1: While reset is asserted, and until the first access completes, rsp_valid, rsp_hit, rsp_hiz and rsp_bus_error are 0. After reset the map type is 101, so an access at window address 0x7FFFFF is a RAM hit.
- R2: Each cycle with acc_valid high produces rsp_valid high in the following cycle. A cycle without a strobe produces rsp_valid low and all outcome flags, rsp_offset and rsp_fill at 0 in the following cycle.
- R3: Every response raises exactly one of rsp_hit, rsp_hiz and rsp_bus_error.
- R4: A write takes the map type from bits 11:9 of cfg_wdata and ignores the other bits. The new value governs strobes in cycles after the write cycle. A strobe in the write cycle itself still uses the old value.
- R5: The RAM region starts at address 0. Its size, selected by map-type bits {0,2}, is: 00 gives 1 MB, 01 gives 2 MB, 10 gives 4 MB and 11 gives 8 MB. For example, 000 gives 1 MB, 100 gives 2 MB, 001 and 011 give 4 MB, and 101 and 111 give 8 MB.
- R6: When map-type bit 1 is set, the region directly above the RAM, equal to it in size, is floating and answers with rsp_hiz. This applies to 010, 011 and 110.
- R7: Any address in the window that is neither RAM nor floating raises rsp_bus_error.
- R8: On a RAM hit, rsp_offset is the address modulo the installed size. With ram_large=1 (8 MB) that is the full address; with ram_large=0 (2 MB) it is the low 21 bits. rsp_offset is 0 on any other response.
- R9: rsp_fill is all ones on a floating response and 0 otherwise.
- R10: With 2 MB fitted and an 8 MB map, addresses that differ by 2, 4 or 6 MB give the same rsp_offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Single-cycle write enable for the control word |
| cfg_wdata | input | 32 | Control word; map type in bits 11:9 |
| ram_large | input | 1 | Installed RAM: 1 = 8 MB, 0 = 2 MB |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 23 | Byte address within the window |
| rsp_valid | output | 1 | Response for the previous cycle's strobe |
| rsp_hit | output | 1 | Access hit RAM |
| rsp_hiz | output | 1 | Access hit a floating region |
| rsp_bus_error | output | 1 | Access hit an invalid region |
| rsp_offset | output | 23 | Physical RAM offset on a hit |
| rsp_fill | output | 32 | Read data for a floating access |

## Verification
The assertions assume that ram_large is steady whenever a strobe is presented. They also assume that acc_addr is only meaningful while acc_valid is high. The bench therefore changes ram_large and the map type only in cycles without a strobe. The one exception is the deliberate write-with-access case, which exercises the old-value rule. Strobes last exactly one cycle and are driven on the falling edge, so the decode inputs are settled well before the capturing edge.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_RAM  = 2'd1,
    RES_HIZ  = 2'd2,
    RES_ERR  = 2'd3
  } mwd_res_e;
endpackage

// File: rtl/mwd_mapreg.sv
module mwd_mapreg #(
  parameter int          REG_W     = 32,
  parameter int          MAP_LSB   = 9,
  parameter int          MAP_W     = 3,
  parameter logic [2:0]  RESET_MAP = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [MAP_W-1:0] map_type
);
  logic [MAP_W-1:0] map_d;

  always_comb begin
    map_d = map_type;
    if (we) map_d = wdata[MAP_LSB +: MAP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_type <= MAP_W'(RESET_MAP);
    else        map_type <= map_d;
  end

  // R4: the field only moves on a write
  a_r4_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(map_type));
  a_r4_map_loads: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (map_type == $past(wdata[MAP_LSB +: MAP_W])));
endmodule

// File: rtl/mwd_region_dec.sv
module mwd_region_dec
  import mwd_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int UNIT_SHIFT = 20,
  parameter int SMALL_W    = 21
) (
  input  logic [2:0]        map_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ram_large,
  output mwd_res_e          result,
  output logic [ADDR_W-1:0] offset
);
  localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
  localparam int CMP_W  = UNIT_W + 2;
  localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((64'(1) << SMALL_W) - 64'(1));

  logic [1:0]       size_log;
  logic [CMP_W-1:0] unit_idx;
  logic [CMP_W-1:0] ram_units;
  logic [CMP_W-1:0] float_top;
  logic [ADDR_W-1:0] wrap_addr;

  always_comb begin
    // RAM size in 1 MB units: {bit0,bit2} gives log2 of the size
    size_log  = {map_type[0], map_type[2]};
    ram_units = CMP_W'(1) << size_log;
    float_top = ram_units << 1;
    unit_idx  = CMP_W'(addr[ADDR_W-1:UNIT_SHIFT]);
    wrap_addr = ram_large ? addr : (addr & SMALL_MASK);

    if (unit_idx < ram_units) begin
      result = RES_RAM;
      offset = wrap_addr;
    end else if (map_type[1] && (unit_idx < float_top)) begin
      result = RES_HIZ;
      offset = '0;
    end else begin
      result = RES_ERR;
      offset = '0;
    end
  end
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int REG_W      = 32,
  parameter int MAP_LSB    = 9,
  parameter int DATA_W     = 32,
  parameter int UNIT_SHIFT = 20,
  parameter int SMALL_W    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              ram_large,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_hiz,
  output logic              rsp_bus_error,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [DATA_W-1:0] rsp_fill
);
  localparam int MAP_W = 3;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic [MAP_W-1:0]  map_type;
  mwd_res_e          dec_res;
  logic [ADDR_W-1:0] dec_off;

  mwd_mapreg #(
    .REG_W(REG_W), .MAP_LSB(MAP_LSB), .MAP_W(MAP_W), .RESET_MAP(3'b101)
  ) i_mapreg (
    .clk(clk), .rst_n(rst_s_n), .we(cfg_we), .wdata(cfg_wdata), .map_type(map_type)
  );

  mwd_region_dec #(
    .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .SMALL_W(SMALL_W)
  ) i_dec (
    .map_type(map_type), .addr(acc_addr), .ram_large(ram_large),
    .result(dec_res), .offset(dec_off)
  );

  // next-state for the response registers
  logic              valid_d, hit_d, hiz_d, err_d;
  logic [ADDR_W-1:0] off_d;
  logic [DATA_W-1:0] fill_d;

  always_comb begin
    valid_d = acc_valid;
    hit_d   = acc_valid && (dec_res == RES_RAM);
    hiz_d   = acc_valid && (dec_res == RES_HIZ);
    err_d   = acc_valid && (dec_res == RES_ERR);
    off_d   = hit_d ? dec_off : '0;
    fill_d  = hiz_d ? '1 : '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_hiz       <= 1'b0;
      rsp_bus_error <= 1'b0;
      rsp_offset    <= '0;
      rsp_fill      <= '0;
    end else begin
      rsp_valid     <= valid_d;
      rsp_hit       <= hit_d;
      rsp_hiz       <= hiz_d;
      rsp_bus_error <= err_d;
      rsp_offset    <= off_d;
      rsp_fill      <= fill_d;
    end
  end

  // R2: one-cycle response latency, quiet when idle
  a_r2_strobe_answered: assert property (@(posedge clk) disable iff (!rst_s_n)
    acc_valid |=> rsp_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    !acc_valid |=> (!rsp_valid && !rsp_hit && !rsp_hiz && !rsp_bus_error));
  // R3: one outcome per response
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_hiz, rsp_bus_error}) == 1));
  // R8: no offset leaks out on a non-RAM response
  a_r8_offset_only_on_hit: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rsp_hit |-> (rsp_offset == '0));
  // R10: with small RAM fitted the offset stays within it
  a_r10_small_wraps: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_hit && !$past(ram_large)) |-> ((rsp_offset >> SMALL_W) == '0));
  // R9: fill pattern tracks the floating outcome
  a_r9_fill_ones: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_hiz |-> (rsp_fill == '1));
  a_r9_fill_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rsp_hiz |-> (rsp_fill == '0));
endmodule

// File: tb/test_mem_window_decoder.sv
module test_mem_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        ram_large;
  logic        acc_valid;
  logic [22:0] acc_addr;
  logic        rsp_valid, rsp_hit, rsp_hiz, rsp_bus_error;
  logic [22:0] rsp_offset;
  logic [31:0] rsp_fill;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  mem_window_decoder i_mem_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ram_large(ram_large), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hiz(rsp_hiz),
    .rsp_bus_error(rsp_bus_error), .rsp_offset(rsp_offset), .rsp_fill(rsp_fill)
  );

  // outcome codes: 0 none, 1 RAM, 2 floating, 3 bus error
  typedef struct packed {
    logic [2:0]  map;
    logic        big;
    logic [22:0] addr;
    logic [1:0]  res;
    logic [22:0] off;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b1, 23'h0FFFFF, 2'd1, 23'h0FFFFF},
    '{3'b000, 1'b1, 23'h100000, 2'd3, 23'h000000},
    '{3'b001, 1'b1, 23'h3FFFFC, 2'd1, 23'h3FFFFC},
    '{3'b001, 1'b1, 23'h400000, 2'd3, 23'h000000},
    '{3'b010, 1'b1, 23'h0ABCDE, 2'd1, 23'h0ABCDE},
    '{3'b010, 1'b1, 23'h1ABCDE, 2'd2, 23'h000000},
    '{3'b010, 1'b1, 23'h200000, 2'd3, 23'h000000},
    '{3'b011, 1'b1, 23'h500000, 2'd2, 23'h000000},
    '{3'b011, 1'b1, 23'h7FFFFF, 2'd2, 23'h000000},
    '{3'b100, 1'b1, 23'h1FFFFF, 2'd1, 23'h1FFFFF},
    '{3'b100, 1'b1, 23'h200000, 2'd3, 23'h000000},
    '{3'b101, 1'b1, 23'h654321, 2'd1, 23'h654321},
    '{3'b110, 1'b1, 23'h312345, 2'd2, 23'h000000},
    '{3'b110, 1'b1, 23'h412345, 2'd3, 23'h000000},
    '{3'b111, 1'b0, 23'h612345, 2'd1, 23'h012345},
    '{3'b101, 1'b0, 23'h2ABCDE, 2'd1, 23'h0ABCDE},
    '{3'b011, 1'b0, 23'h3FFFF0, 2'd1, 23'h1FFFF0},
    '{3'b110, 1'b0, 23'h1FFFFF, 2'd1, 23'h1FFFFF}
  };

  function automatic logic [1:0] act_code();
    if (!rsp_valid) return 2'd0;
    if (rsp_hit && !rsp_hiz && !rsp_bus_error) return 2'd1;
    if (rsp_hiz && !rsp_hit && !rsp_bus_error) return 2'd2;
    if (rsp_bus_error && !rsp_hit && !rsp_hiz) return 2'd3;
    return 2'bxx;
  endfunction

  task automatic check(string req, logic [1:0] exp_res, logic [22:0] exp_off);
    logic [31:0] exp_fill;
    exp_fill = (exp_res == 2'd2) ? 32'hFFFF_FFFF : 32'h0;
    n_checks++;
    if (act_code() !== exp_res || rsp_offset !== exp_off || rsp_fill !== exp_fill) begin
      n_fail++;
      $display("FAIL %s: got res=%0d off=%h fill=%h, expected res=%0d off=%h fill=%h",
               req, act_code(), rsp_offset, rsp_fill, exp_res, exp_off, exp_fill);
    end
  endtask

  task automatic write_map(logic [2:0] m);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {20'hA5A5A, m, 9'h1FF};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic access(logic [22:0] a);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = a;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_addr  = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; ram_large = 1'b1;
    acc_valid = 1'b0; acc_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 2'd0, 23'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: default map is full-window RAM
    access(23'h7FFFFF);
    check("R1 default map 101", 2'd1, 23'h7FFFFF);

    // R2: no strobe, no response
    @(negedge clk);
    check("R2 idle", 2'd0, 23'h0);

    // table walk: R3, R5, R6, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      write_map(VECS[i].map);
      ram_large = VECS[i].big;
      access(VECS[i].addr);
      case (VECS[i].res)
        2'd1:    check($sformatf("R5/R8 vec %0d", i), VECS[i].res, VECS[i].off);
        2'd2:    check($sformatf("R6/R9 vec %0d", i), VECS[i].res, VECS[i].off);
        default: check($sformatf("R7/R3 vec %0d", i), VECS[i].res, VECS[i].off);
      endcase
    end

    // R4: bits outside 11:9 ignored (all ones elsewhere, field 000)
    ram_large = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_F1FF;
    @(negedge clk);
    cfg_we = 1'b0;
    access(23'h100000);
    check("R4 field isolation", 2'd3, 23'h0);

    // R4: write and access in the same cycle use the old map
    write_map(3'b101);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0000;
    acc_valid = 1'b1; acc_addr = 23'h500000;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    check("R4 same-cycle uses old map", 2'd1, 23'h500000);
    access(23'h500000);
    check("R4 new map after write", 2'd3, 23'h0);

    // R10: mirroring of 2 MB across an 8 MB map
    write_map(3'b101);
    ram_large = 1'b0;
    for (int k = 0; k < 4; k++) begin
      access(23'(k * 23'h200000 + 23'h012340));
      check($sformatf("R10 mirror copy %0d", k), 2'd1, 23'h012340);
    end

    // R2: back-to-back strobes each answered
    ram_large = 1'b1;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 23'h000004;
    @(negedge clk);
    acc_addr = 23'h000008;
    check("R2 back-to-back first", 2'd1, 23'h000004);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R2 back-to-back second", 2'd1, 23'h000008);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule